// File: doc/BRIEF.md
# LUT-fed chained adder cell

This block is a configurable arithmetic logic cell and a cascade of such cells. Each cell holds four 4-input lookup tables in two pairs. Each pair feeds one dedicated full adder, so every adder sums two freely programmed 4-input functions and an incoming carry. The two adders in a cell are chained. The carry from the upper adder leaves the cell and enters the next cell, so a cascade of N cells forms a 2N-bit ripple adder. Each adder bit can be taken straight from the logic or from a register. The register has a clock enable, a synchronous clear and a synchronous load.

Lookup masks are static configuration inputs. With pass-through masks, the cascade adds two operands. If the second operand's tables are inverted and the carry-in is 1, it subtracts them. A per-bit mode puts a raw table output on the data output in place of the sum. In that mode the carry still ripples through the bit. This lets one bit position carry both a logic function and part of a carry chain.

Top module: `lac_chain`

## Requirements
- R1: Table input index bit 0 is `in_a`, bit 1 is `in_b`, bit 2 is `in_c` (even bit) or `in_d` (odd bit), and bit 3 is the e input (`in_e0`/`in_e1`) for the first table of a pair or the f input (`in_f0`/`in_f1`) for the second. The output is mask bit [index]. For bit i of cell k = i/2, the first table's mask is `lut_cfg[(4k+2(i%2))*16 +: 16]` and the second table's mask is the next 16 bits.
- R2: When `lut_mode[i]`=0, `comb_out[i]` is bit 0 of (first table + second table + carry into bit i). The carry out of bit i is bit 1 of that sum.
- R3: `cin` enters bit 0, carries ripple upward bit by bit across cells, and `cout` is the carry out of the top bit. With masks 16'hF0F0 on first tables and 16'hFF00 on second tables, {`cout`,`comb_out`} = A + B + `cin`, where bit i of A drives `in_c`/`in_d` and bit i of B drives `in_f0`/`in_f1`.
- R4: With masks 16'h00FF on second tables and `cin`=1, {`cout`,`comb_out`} = A + ~B + 1. That is A - B modulo 2^W, with `cout`=1 exactly when A >= B.
- R5: When `lut_mode[i]`=1, `comb_out[i]` equals the first table's output. The carry out of bit i and `cout` are the same as when the mode is 0.
- R6: On a clock edge with `ce`=1 and no clear or load acting on bit i, `reg_out[i]` takes the value `comb_out[i]` had before the edge.
- R7: On a clock edge with `ce`=0, `reg_out` keeps its value whatever `sclr` and `sload` are.
- R8: On an edge with `ce`=1 and `sclr`=1, every bit with `clr_en[i]`=1 becomes 0. Bits with `clr_en[i]`=0 ignore `sclr`.
- R9: On an edge with `ce`=1 and `sload`=1, every bit with `ld_en[i]`=1 takes `ld_val[i]`. Bits with `ld_en[i]`=0 ignore `sload`.
- R10: A clear acting on a bit wins over a load on the same edge. A load wins over the normal capture.
- R11: `rst`=1 at a clock edge sets all of `reg_out` to 0, whatever `ce` is.
- R12: All four tables of a cell see the same `in_a` and `in_b` bits, so a mask that depends on them, such as a XOR b (16'h6666), acts in all four tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| ce | input | 1 | Register clock enable, shared by all bits |
| sclr | input | 1 | Synchronous clear, shared by all bits |
| sload | input | 1 | Synchronous load, shared by all bits |
| cin | input | 1 | Carry into bit 0 |
| in_a | input | CELLS | Shared table input a, one bit per cell |
| in_b | input | CELLS | Shared table input b, one bit per cell |
| in_c | input | CELLS | Table input for the lower pair of each cell |
| in_d | input | CELLS | Table input for the upper pair of each cell |
| in_e0 | input | CELLS | Fourth input of the lower pair's first table |
| in_f0 | input | CELLS | Fourth input of the lower pair's second table |
| in_e1 | input | CELLS | Fourth input of the upper pair's first table |
| in_f1 | input | CELLS | Fourth input of the upper pair's second table |
| lut_cfg | input | 64*CELLS | Table masks, 16 bits per table, four tables per cell |
| lut_mode | input | 2*CELLS | Per bit: 1 puts the first table's output on the data output |
| clr_en | input | 2*CELLS | Per-bit permission for the shared clear |
| ld_en | input | 2*CELLS | Per-bit permission for the shared load |
| ld_val | input | 2*CELLS | Per-bit load value |
| comb_out | output | 2*CELLS | Unregistered bit outputs |
| reg_out | output | 2*CELLS | Registered bit outputs |
| cout | output | 1 | Carry out of the top bit |

## Verification
A wrong table index or a broken carry link shows on `comb_out` and `cout` in the same cycle. Sums land on the wrong value, and the error usually spreads into the higher bits through the ripple. A wrong register priority or enable gating shows on `reg_out` right after the edge where clear, load and capture meet. The state then persists until the next capture, so the error stays visible. The bench keeps a cycle-accurate model of every register bit and of the combinational result and compares all outputs on every clock. Arithmetic phases also compare against plain integer sums and differences.

// File: rtl/lac_pkg.sv
package lac_pkg;
  localparam int LUT_IN        = 4;
  localparam int LUT_MASK_W    = 1 << LUT_IN;
  localparam int LUTS_PER_CELL = 4;
  localparam int BITS_PER_CELL = 2;
  localparam int CELL_CFG_W    = LUTS_PER_CELL * LUT_MASK_W;

  typedef logic [LUT_MASK_W-1:0] lut_mask_t;

  typedef struct packed {
    logic ce;
    logic sclr;
    logic sload;
  } reg_ctrl_t;
endpackage

// File: rtl/lac_lut.sv
module lac_lut
  import lac_pkg::*;
(
  input  lut_mask_t         mask,
  input  logic [LUT_IN-1:0] sel,
  output logic              y
);
  assign y = mask[sel];
endmodule

// File: rtl/lac_slice.sv
module lac_slice
  import lac_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  reg_ctrl_t ctrl,
  input  logic      a,
  input  logic      b,
  input  logic      m,
  input  logic      e,
  input  logic      f,
  input  lut_mask_t mask_e,
  input  lut_mask_t mask_f,
  input  logic      lut_mode,
  input  logic      clr_en,
  input  logic      ld_en,
  input  logic      ld_val,
  input  logic      ci,
  output logic      co,
  output logic      comb,
  output logic      q
);
  logic       le;
  logic       lf;
  logic [1:0] sum;

  lac_lut u_lut_e (.mask(mask_e), .sel({e, m, b, a}), .y(le));
  lac_lut u_lut_f (.mask(mask_f), .sel({f, m, b, a}), .y(lf));

  assign sum  = {1'b0, le} + {1'b0, lf} + {1'b0, ci};
  assign co   = sum[1];
  assign comb = lut_mode ? le : sum[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (ctrl.ce) begin
      if (ctrl.sclr && clr_en)
        q <= 1'b0;
      else if (ctrl.sload && ld_en)
        q <= ld_val;
      else
        q <= comb;
    end
  end
endmodule

// File: rtl/lac_cell.sv
module lac_cell
  import lac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  reg_ctrl_t                ctrl,
  input  logic                     a,
  input  logic                     b,
  input  logic                     c,
  input  logic                     d,
  input  logic                     e0,
  input  logic                     f0,
  input  logic                     e1,
  input  logic                     f1,
  input  logic [CELL_CFG_W-1:0]    cfg,
  input  logic [BITS_PER_CELL-1:0] mode,
  input  logic [BITS_PER_CELL-1:0] clr_en,
  input  logic [BITS_PER_CELL-1:0] ld_en,
  input  logic [BITS_PER_CELL-1:0] ld_val,
  input  logic                     ci,
  output logic                     co,
  output logic [BITS_PER_CELL-1:0] comb,
  output logic [BITS_PER_CELL-1:0] q
);
  logic [BITS_PER_CELL:0]   chain;
  logic [BITS_PER_CELL-1:0] m_in;
  logic [BITS_PER_CELL-1:0] e_in;
  logic [BITS_PER_CELL-1:0] f_in;

  assign m_in     = {d, c};
  assign e_in     = {e1, e0};
  assign f_in     = {f1, f0};
  assign chain[0] = ci;
  assign co       = chain[BITS_PER_CELL];

  for (genvar p = 0; p < BITS_PER_CELL; p++) begin : g_slice
    lac_slice u_slice (
      .clk     (clk),
      .rst     (rst),
      .ctrl    (ctrl),
      .a       (a),
      .b       (b),
      .m       (m_in[p]),
      .e       (e_in[p]),
      .f       (f_in[p]),
      .mask_e  (cfg[(2*p)*LUT_MASK_W +: LUT_MASK_W]),
      .mask_f  (cfg[(2*p+1)*LUT_MASK_W +: LUT_MASK_W]),
      .lut_mode(mode[p]),
      .clr_en  (clr_en[p]),
      .ld_en   (ld_en[p]),
      .ld_val  (ld_val[p]),
      .ci      (chain[p]),
      .co      (chain[p+1]),
      .comb    (comb[p]),
      .q       (q[p])
    );
  end
endmodule

// File: rtl/lac_chain.sv
module lac_chain
  import lac_pkg::*;
#(
  parameter int CELLS = 4,
  localparam int W    = BITS_PER_CELL * CELLS,
  localparam int CFGW = CELL_CFG_W * CELLS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic            sclr,
  input  logic            sload,
  input  logic            cin,
  input  logic [CELLS-1:0] in_a,
  input  logic [CELLS-1:0] in_b,
  input  logic [CELLS-1:0] in_c,
  input  logic [CELLS-1:0] in_d,
  input  logic [CELLS-1:0] in_e0,
  input  logic [CELLS-1:0] in_f0,
  input  logic [CELLS-1:0] in_e1,
  input  logic [CELLS-1:0] in_f1,
  input  logic [CFGW-1:0] lut_cfg,
  input  logic [W-1:0]    lut_mode,
  input  logic [W-1:0]    clr_en,
  input  logic [W-1:0]    ld_en,
  input  logic [W-1:0]    ld_val,
  output logic [W-1:0]    comb_out,
  output logic [W-1:0]    reg_out,
  output logic            cout
);
  reg_ctrl_t        ctrl;
  logic [CELLS:0]   carry;

  assign ctrl     = '{ce: ce, sclr: sclr, sload: sload};
  assign carry[0] = cin;
  assign cout     = carry[CELLS];

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    lac_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .ctrl  (ctrl),
      .a     (in_a[k]),
      .b     (in_b[k]),
      .c     (in_c[k]),
      .d     (in_d[k]),
      .e0    (in_e0[k]),
      .f0    (in_f0[k]),
      .e1    (in_e1[k]),
      .f1    (in_f1[k]),
      .cfg   (lut_cfg[k*CELL_CFG_W +: CELL_CFG_W]),
      .mode  (lut_mode[k*BITS_PER_CELL +: BITS_PER_CELL]),
      .clr_en(clr_en[k*BITS_PER_CELL +: BITS_PER_CELL]),
      .ld_en (ld_en[k*BITS_PER_CELL +: BITS_PER_CELL]),
      .ld_val(ld_val[k*BITS_PER_CELL +: BITS_PER_CELL]),
      .ci    (carry[k]),
      .co    (carry[k+1]),
      .comb  (comb_out[k*BITS_PER_CELL +: BITS_PER_CELL]),
      .q     (reg_out[k*BITS_PER_CELL +: BITS_PER_CELL])
    );
  end
endmodule

// File: rtl/lac_chain_chk.sv
module lac_chain_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ce,
  input logic         sclr,
  input logic         sload,
  input logic [W-1:0] clr_en,
  input logic [W-1:0] ld_en,
  input logic [W-1:0] ld_val,
  input logic [W-1:0] comb_out,
  input logic [W-1:0] reg_out
);
  logic [W-1:0] clr_hit;
  logic [W-1:0] ld_hit;

  assign clr_hit = {W{sclr}} & clr_en;
  assign ld_hit  = {W{sload}} & ld_en & ~clr_hit;

  // R11
  reset_clear_chk: assert property (@(posedge clk) rst |=> (reg_out == '0));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(reg_out));

  // R8
  sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && sclr) |=> ((reg_out & $past(clr_en)) == '0));

  // R9 R10
  sync_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && sload) |=> (((reg_out ^ $past(ld_val)) & $past(ld_hit)) == '0));

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> (((reg_out ^ $past(comb_out)) & ~$past(clr_hit | ld_hit)) == '0));
endmodule

bind lac_chain lac_chain_chk #(.W(W)) u_lac_chain_chk (
  .clk     (clk),
  .rst     (rst),
  .ce      (ce),
  .sclr    (sclr),
  .sload   (sload),
  .clr_en  (clr_en),
  .ld_en   (ld_en),
  .ld_val  (ld_val),
  .comb_out(comb_out),
  .reg_out (reg_out)
);

// File: tb/test_lac_chain.sv
module test_lac_chain;
  localparam int CLK_PERIOD = 10;
  localparam int CELLS = 4;
  localparam int W     = 2 * CELLS;
  localparam int CFGW  = 64 * CELLS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, sclr = 1'b0, sload = 1'b0, cin = 1'b0;
  logic [CELLS-1:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic [CELLS-1:0] in_e0 = '0, in_f0 = '0, in_e1 = '0, in_f1 = '0;
  logic [CFGW-1:0] lut_cfg = '0;
  logic [W-1:0] lut_mode = '0, clr_en = '0, ld_en = '0, ld_val = '0;
  logic [W-1:0] comb_out, reg_out;
  logic cout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag_c = "R2";
  string tag_r = "R11";
  int arith = 0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] m_reg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lac_chain #(.CELLS(CELLS)) i_lac_chain (.*);

  function automatic logic [W:0] model_comb();
    logic c = cin;
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      int k = i / 2;
      int p = i % 2;
      int s;
      logic [3:0] ie, jf;
      logic le, lf;
      ie = {p ? in_e1[k] : in_e0[k], p ? in_d[k] : in_c[k], in_b[k], in_a[k]};
      jf = {p ? in_f1[k] : in_f0[k], p ? in_d[k] : in_c[k], in_b[k], in_a[k]};
      le = lut_cfg[(4*k + 2*p) * 16 + int'(ie)];
      lf = lut_cfg[(4*k + 2*p + 1) * 16 + int'(jf)];
      s = int'(le) + int'(lf) + int'(c);
      r[i] = lut_mode[i] ? le : s[0];
      c = s[1];
    end
    return {c, r};
  endfunction

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // register model: updated at each edge from the inputs held there
  always @(posedge clk) begin
    logic [W:0] mc;
    mc = model_comb();
    if (rst) m_reg <= '0;
    else if (ce) begin
      for (int i = 0; i < W; i++) begin
        if (sclr && clr_en[i]) m_reg[i] <= 1'b0;
        else if (sload && ld_en[i]) m_reg[i] <= ld_val[i];
        else m_reg[i] <= mc[i];
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic [W:0] full;
      check(tag_c, {cout, comb_out}, model_comb());
      check(tag_r, {1'b0, reg_out}, {1'b0, m_reg});
      full = {1'b0, op_a} + {1'b0, op_b} + (W+1)'(cin);
      if (arith == 1) check("R3", {cout, comb_out}, full);
      if (arith == 2) check("R4", {cout, comb_out}, {1'b0, op_a} + {1'b0, ~op_b} + (W+1)'(1));
      if (arith == 3) begin
        check("R5", {cout, comb_out},
              {full[W], (full[W-1:0] & ~lut_mode) | (op_a & lut_mode)});
      end
    end
  end

  task automatic cfg_arith(bit sub);
    for (int k = 0; k < CELLS; k++) begin
      lut_cfg[(4*k)*16 +: 16]   = 16'hF0F0;
      lut_cfg[(4*k+1)*16 +: 16] = sub ? 16'h00FF : 16'hFF00;
      lut_cfg[(4*k+2)*16 +: 16] = 16'hF0F0;
      lut_cfg[(4*k+3)*16 +: 16] = sub ? 16'h00FF : 16'hFF00;
    end
  endtask

  task automatic set_ops(logic [W-1:0] a, logic [W-1:0] b);
    op_a = a; op_b = b;
    for (int k = 0; k < CELLS; k++) begin
      in_c[k] = a[2*k]; in_d[k] = a[2*k+1];
      in_f0[k] = b[2*k]; in_f1[k] = b[2*k+1];
    end
    in_a = CELLS'($urandom); in_b = CELLS'($urandom);
    in_e0 = CELLS'($urandom); in_e1 = CELLS'($urandom);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    // R11 reset state
    repeat (3) step();
    rst = 0; ce = 1;
    cfg_arith(0);
    // R2 R3 R6: addition across random and corner operands
    tag_c = "R3"; tag_r = "R6"; arith = 1;
    set_ops('1, 8'h01); cin = 0; step();
    set_ops('1, '1); cin = 1; step();
    set_ops('0, '0); cin = 1; step();
    for (int n = 0; n < 300; n++) begin
      set_ops(W'($urandom), W'($urandom)); cin = 1'($urandom); step();
    end
    // R4: subtraction
    tag_c = "R4"; arith = 2; cfg_arith(1); cin = 1;
    set_ops(8'h05, 8'h05); step();
    set_ops(8'h00, 8'h01); step();
    for (int n = 0; n < 200; n++) begin
      set_ops(W'($urandom), W'($urandom)); step();
    end
    // R5: raw table output while the carry ripples
    tag_c = "R5"; arith = 3; cfg_arith(0);
    for (int n = 0; n < 200; n++) begin
      lut_mode = W'($urandom);
      set_ops(W'($urandom), W'($urandom)); cin = 1'($urandom); step();
    end
    lut_mode = '0;
    // R7: clock enable gating, with clear/load pulses that must be ignored
    tag_r = "R7"; arith = 1;
    for (int n = 0; n < 200; n++) begin
      ce = 1'($urandom); sclr = ($urandom % 4) == 0; sload = ($urandom % 4) == 0;
      clr_en = '1; ld_en = '1; ld_val = W'($urandom);
      if (ce) begin sclr = 0; sload = 0; end
      set_ops(W'($urandom), W'($urandom)); step();
    end
    // R8 R9 R10: clear and load with per-bit permissions
    ce = 1; arith = 0;
    tag_r = "R8";
    set_ops('1, '0); cin = 0; sclr = 1; clr_en = 8'h0F; step();
    tag_r = "R9";
    sclr = 0; sload = 1; ld_en = 8'h3C; ld_val = 8'hA5; step();
    tag_r = "R10";
    sclr = 1; sload = 1; clr_en = 8'hFF; ld_en = 8'hFF; step();
    for (int n = 0; n < 400; n++) begin
      ce = ($urandom % 5) != 0; sclr = 1'($urandom); sload = 1'($urandom);
      clr_en = W'($urandom); ld_en = W'($urandom); ld_val = W'($urandom);
      set_ops(W'($urandom), W'($urandom)); cin = 1'($urandom); step();
    end
    sclr = 0; sload = 0; ce = 1;
    // R12: shared a/b inputs feed all four tables (XOR of a and b)
    tag_c = "R12"; tag_r = "R6";
    for (int k = 0; k < 4*CELLS; k++) lut_cfg[k*16 +: 16] = 16'h6666;
    for (int n = 0; n < 100; n++) begin
      in_a = CELLS'($urandom); in_b = CELLS'($urandom); cin = 1'($urandom);
      lut_mode = W'($urandom); step();
    end
    // R1: arbitrary masks exercise every index bit position
    tag_c = "R1";
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < 4*CELLS; k++) lut_cfg[k*16 +: 16] = 16'($urandom);
      {in_a, in_b, in_c, in_d} = 16'($urandom);
      {in_e0, in_f0, in_e1, in_f1} = 16'($urandom);
      lut_mode = W'($urandom); cin = 1'($urandom);
      ce = 1'($urandom); step();
    end
    // R11: reset mid-run, with ce low
    tag_r = "R11"; ce = 0; rst = 1; step(); step();
    rst = 0; step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule